// File: doc/BRIEF.md
# Two-Channel Gated Interrupt Controller

This block takes event strobes for two interrupt channels from a small CPU core. It turns them into a single interrupt request line, a branch target, and a strobe that tells the core to push its program counter.

Each channel counts its events against a threshold chosen by a 3-bit select code. When the count reaches that threshold, the channel latches a pending request. A pending request reaches the CPU only when two gates are open: the channel's software enable bit and its internal arm flip-flop. The core acknowledges the request. The block then clears the pending request and the arm flip-flop of the serviced channel, and it clears the software enable bits of both channels. One cycle after the acknowledge, the block presents the channel's fixed entry address together with a one-cycle push strobe.

The event counters are never disturbed by service. A return strobe issued while a channel's enable bit is 1 re-arms that channel's flip-flop. If the service routine sets the enable bits again before it returns, the other channel can interrupt it.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` and `push_o` are 0. Both enable bits reset to 0, and both arm flip-flops reset to 1.
- R2: With select code c (1..7) on a channel, every c*STEP-th event on that channel's `evt_i` bit latches a pending request. The request is visible in the cycle after the clock edge that samples the final event. Bit 0 is channel 1, and `sel_i[2:0]` / `sel_i[5:3]` select channel 1 / channel 2.
- R3: `irq_o` is 1 only while some channel has a pending request, its enable bit set and its arm flip-flop set. A request latched while its enable bit is 0 stays pending and is forwarded as soon as the bit is written to 1 through `en_wr_i`/`en_wdata_i`, where bit 0 is channel 1.
- R4: When `ack_i` is sampled while `irq_o` is 1, the following effects appear on the next cycle:
  - `push_o` is 1 for exactly one cycle.
  - `vector_o` carries the entry address of the serviced channel (`ENTRY1` or `ENTRY2`).
  - That channel's pending request and arm flip-flop are cleared.
  - Both enable bits are cleared. An enable write in the same cycle loses.
- R5: When both channels are eligible in the same cycle, channel 1 is serviced first.
- R6: The event counters are not reset by an acknowledge. Events counted before service still count toward the next request.
- R7: A `ret_i` strobe sets the arm flip-flop of each channel whose enable bit is 1 at that time. A `ret_i` strobe with the enable bit at 0 leaves that channel's flip-flop cleared.
- R8: Select code 000 holds the channel's counter at zero, and that channel raises no request regardless of its events.
- R9: `ack_i` sampled while `irq_o` is 0 is ignored. It produces no `push_o` and does not clear the enable bits.
- R10: While one channel is in service, rewriting the enable bits lets the other channel, whose arm flip-flop is still set, interrupt before the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 2 | One-cycle event strobes, bit 0 channel 1 |
| sel_i | input | 6 | Threshold select codes, [2:0] channel 1, [5:3] channel 2 |
| en_wr_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | 2 | New enable bits, bit 0 channel 1 |
| ack_i | input | 1 | CPU acknowledge of the interrupt request |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| push_o | output | 1 | One-cycle strobe: push the program counter |
| vector_o | output | ADDR_W | Entry address of the serviced channel |

## Verification
The bench latches a request while the enable bits are 0 and then opens them. A controller that dropped the request, or forwarded it too early, would miss or spuriously raise `irq_o`. It issues returns with the enable bit both cleared and set, and it services a second channel nested inside the first. A design that re-armed unconditionally, or that cleared the wrong flip-flop, would interrupt at the wrong point. It also leaves a counter partway through its count across an acknowledge: a counter reset on service would need a full new count before raising the next request. Further cases cover simultaneous requests, where a wrong priority shows up on `vector_o`; code 000 under a burst of events; and an acknowledge with no request, which must neither push nor clear the enable bits.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned SEL_W = 3;

  // threshold in events for one select code
  function automatic int unsigned thr_of(input logic [SEL_W-1:0] code,
                                         input int unsigned step);
    return int'(code) * step;
  endfunction
endpackage

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int unsigned STEP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          evt_i,
  input  logic [dual_irq_pkg::SEL_W-1:0] sel_i,
  output logic                          hit_o
);
  localparam int unsigned MAX_THR = ((1 << dual_irq_pkg::SEL_W) - 1) * STEP;
  localparam int unsigned CNT_W   = $clog2(MAX_THR + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc, thr;
  logic             idle, cnt_en;

  always_comb begin
    thr     = (CNT_W+1)'(dual_irq_pkg::thr_of(sel_i, STEP));
    idle    = (sel_i == '0);
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit_o   = evt_i && !idle && (cnt_inc >= thr);
    cnt_en  = idle || evt_i;
    if (idle)       cnt_d = '0;
    else if (hit_o) cnt_d = '0;
    else            cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: a prohibited code parks the counter at zero
  a_r8_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == '0));
  // R6: an event below the threshold advances the count by one
  a_r6_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !idle && !hit_o) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/irq_chan_latch.sv
module irq_chan_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic take_i,
  input  logic ret_i,
  input  logic en_bit_i,
  output logic elig_o
);
  logic req_q, req_d, arm_q, arm_d;

  always_comb begin
    if (hit_i)       req_d = 1'b1;
    else if (take_i) req_d = 1'b0;
    else             req_d = req_q;

    if (take_i)                 arm_d = 1'b0;
    else if (ret_i && en_bit_i) arm_d = 1'b1;
    else                        arm_d = arm_q;

    elig_o = req_q && arm_q && en_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      arm_q <= 1'b1;
    end else begin
      req_q <= req_d;
      arm_q <= arm_d;
    end
  end

  a_r2_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> req_q);
  a_r4_take_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !arm_q);
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && en_bit_i && !take_i) |=> arm_q);
  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !en_bit_i && !arm_q) |=> !arm_q);
endmodule

// File: rtl/irq_grant.sv
module irq_grant #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] elig_i,
  output logic [NCH-1:0] grant_o,
  output logic           any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig_i[i]) grant_o = NCH'(1) << i;
    end
    any_o = |elig_i;
  end

  // R5: lowest-numbered eligible channel wins
  always_comb begin
    if (elig_i[0]) a_r5_first_wins: assert (grant_o[0] || (elig_i === 'x));
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int unsigned STEP   = 2,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ENTRY1 = 12'h010,
  parameter logic [ADDR_W-1:0] ENTRY2 = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        evt_i,
  input  logic [5:0]        sel_i,
  input  logic              en_wr_i,
  input  logic [1:0]        en_wdata_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] vector_o
);
  import dual_irq_pkg::*;

  localparam logic [NCH-1:0][ADDR_W-1:0] ENTRY_TAB = {ENTRY2, ENTRY1};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NCH-1:0]    hit, elig, grant, take, en_bit_q, en_bit_d;
  logic              any_elig, ack_take, push_q;
  logic [ADDR_W-1:0] vec_q, vec_d;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    irq_evt_counter #(.STEP(STEP)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .evt_i (evt_i[ch]),
      .sel_i (sel_i[ch*SEL_W +: SEL_W]),
      .hit_o (hit[ch])
    );
    irq_chan_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .hit_i    (hit[ch]),
      .take_i   (take[ch]),
      .ret_i    (ret_i),
      .en_bit_i (en_bit_q[ch]),
      .elig_o   (elig[ch])
    );
  end

  irq_grant #(.NCH(NCH)) u_grant (
    .elig_i  (elig),
    .grant_o (grant),
    .any_o   (any_elig)
  );

  always_comb begin
    irq_o    = any_elig;
    ack_take = ack_i && any_elig;
    take     = ack_take ? grant : '0;
    if (ack_take)     en_bit_d = '0;
    else if (en_wr_i) en_bit_d = en_wdata_i;
    else              en_bit_d = en_bit_q;
    vec_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) vec_d = ENTRY_TAB[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_bit_q <= '0;
      push_q   <= 1'b0;
      vec_q    <= '0;
    end else begin
      en_bit_q <= en_bit_d;
      push_q   <= ack_take;
      if (ack_take) vec_q <= vec_d;
    end
  end

  assign push_o   = push_q;
  assign vector_o = vec_q;

  a_r4_push_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    push_o |=> !push_o);
  a_r4_bits_cleared: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_i && irq_o) |=> (en_bit_q == '0));
  a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_i && !irq_o) |=> !push_o);
  a_r3_irq_needs_bit: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (en_bit_q != '0));
endmodule

// File: tb/dual_irq_ctrl_tb_top.sv
module dual_irq_ctrl_tb_top;
  localparam int unsigned STEP = 2;
  localparam logic [11:0] E1 = 12'h010;
  localparam logic [11:0] E2 = 12'h020;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] evt;
  logic [5:0] sel;
  logic en_wr, ack, ret;
  logic [1:0] en_wdata;
  logic irq, push;
  logic [11:0] vec;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dual_irq_ctrl #(.STEP(STEP), .ADDR_W(12), .ENTRY1(E1), .ENTRY2(E2)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .sel_i(sel), .en_wr_i(en_wr),
    .en_wdata_i(en_wdata), .ack_i(ack), .ret_i(ret), .irq_o(irq),
    .push_o(push), .vector_o(vec)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<50000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] s);
    rst_n = 1'b0; evt = '0; sel = s; en_wr = 0; en_wdata = '0; ack = 0; ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_evt(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      evt[ch] = 1'b1; @(negedge clk);
      evt[ch] = 1'b0; @(negedge clk);
    end
  endtask

  task automatic write_en(input logic [1:0] b);
    en_wr = 1; en_wdata = b; @(negedge clk);
    en_wr = 0;
  endtask

  task automatic do_ret;
    ret = 1; @(negedge clk);
    ret = 0;
  endtask

  // acknowledge and check the push cycle
  task automatic do_ack(input string req, input logic exp_push, input logic [11:0] exp_vec);
    ack = 1; @(negedge clk);
    ack = 0;
    check({req, " push"}, 32'(push), 32'(exp_push));
    if (exp_push) check({req, " vector"}, 32'(vec), 32'(exp_vec));
    @(negedge clk);
    check({req, " push one cycle"}, 32'(push), 0);
  endtask

  task automatic t_reset;
    do_reset(6'o11);
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 push after reset", 32'(push), 0);
    pulse_evt(0, 1);
    pulse_evt(0, 1);
    check("R1 enable bits reset low", 32'(irq), 0);
    write_en(2'b01);
    check("R1 arm reset high", 32'(irq), 1);
  endtask

  task automatic t_count;
    do_reset(6'o13);   // ch1 code 3 -> 6 events
    write_en(2'b01);
    pulse_evt(0, 5);
    check("R2 below threshold", 32'(irq), 0);
    pulse_evt(0, 1);
    check("R2 threshold reached", 32'(irq), 1);
  endtask

  task automatic t_hold_and_ack;
    do_reset(6'o11);
    pulse_evt(0, 2);
    check("R3 held while bit 0", 32'(irq), 0);
    write_en(2'b01);
    check("R3 forwarded after enable", 32'(irq), 1);
    do_ack("R4 channel 1", 1'b1, E1);
    check("R4 irq cleared", 32'(irq), 0);
    pulse_evt(0, 2);
    do_ret;            // enable bit is 0: no re-arm
    write_en(2'b01);
    check("R7 return with bit 0 leaves disarmed", 32'(irq), 0);
    do_ret;
    check("R7 return with bit 1 re-arms", 32'(irq), 1);
  endtask

  task automatic t_priority_nested;
    do_reset(6'o11);
    pulse_evt(0, 2);
    pulse_evt(1, 2);
    write_en(2'b11);
    do_ack("R5 channel 1 first", 1'b1, E1);
    check("R4 both bits cleared", 32'(irq), 0);
    write_en(2'b11);
    check("R10 nested channel 2 request", 32'(irq), 1);
    do_ack("R10 channel 2 entry", 1'b1, E2);
  endtask

  task automatic t_counter_runs;
    do_reset(6'o12);   // ch1 code 2 -> 4 events, ch2 code 1 -> 2 events
    pulse_evt(1, 2);
    pulse_evt(0, 3);
    write_en(2'b11);
    check("R5 lone channel 2 request", 32'(irq), 1);
    do_ack("R6 service channel 2", 1'b1, E2);
    write_en(2'b11);
    pulse_evt(0, 1);
    check("R6 count kept across ack", 32'(irq), 1);
    do_ack("R6 channel 1 entry", 1'b1, E1);
  endtask

  task automatic t_idle_code;
    do_reset(6'o10);   // ch1 code 0
    write_en(2'b11);
    pulse_evt(0, 20);
    check("R8 code 000 no request", 32'(irq), 0);
  endtask

  task automatic t_stray_ack;
    do_reset(6'o11);
    write_en(2'b11);
    do_ack("R9 stray ack", 1'b0, E1);
    pulse_evt(0, 2);
    check("R9 bits kept after stray ack", 32'(irq), 1);
  endtask

  initial begin
    t_reset;
    t_count;
    t_hold_and_ack;
    t_priority_nested;
    t_counter_runs;
    t_idle_code;
    t_stray_ack;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule